// File: doc/BRIEF.md
# Ethernet Transmit Frame Assembler

This block produces the byte stream of an outgoing Ethernet frame for a downstream MAC controller. The controller adds the preamble, the start-of-frame delimiter and the frame check sequence, so none of these appear here. Each frame carries the following fields in order:

- the destination address, held in a register the host can write;
- the local source address, captured once after reset;
- a two-byte length field;
- the data field.

A frame starts with a command that gives the payload length and says whether the board's 8-bit slot identifier goes in front of the payload. After the header, the block passes payload bytes from a valid/ready source to a valid/ready sink. It then adds zero padding until the data field reaches the minimum size. A payload that would exceed the maximum data size is cut at that size, its surplus input bytes are consumed and thrown away, and a sticky error flag is raised.

The length field is computed at command time. Because of this, no payload storage is needed and bytes flow through as they arrive.

Top module: `eth_tx_framer`

## Requirements
- R1: After a command is accepted, the first 12 output bytes are the destination address, then the source address, each most significant byte first. The first byte is marked with `out_sof_o`.
- R2: Let n be the payload length plus one if slot mode is on. Bytes 12 and 13 carry the length field, most significant byte first, equal to max(min(n,1500),46). The frame holds exactly 14 plus that many bytes.
- R3: Data-field bytes after the last real payload byte, up to the length in R2, are 0x00.
- R4: `in_ready_o` stays low while the 14 header bytes are being emitted. Payload bytes then appear in their input order, directly after the header or after the slot byte.
- R5: With `cmd_slot_i` set, the first data-field byte equals `slot_id_i` as sampled when the command was accepted.
- R6: If n exceeds 1500, only 1500 data bytes are sent, and the remaining input bytes are accepted and discarded before the next command is accepted. `len_err_o` rises and stays high until reset.
- R7: `src_mac_i` is captured on the first clock after reset is released. Later changes of that input do not affect any frame until the next reset.
- R8: A write on `dst_we_i` takes effect only while no frame is in progress. A write during a frame is ignored, both for that frame and for later ones.
- R9: `out_eof_o` is high only on the last byte of a frame. While `out_valid_o` is high and `out_ready_i` is low, the output byte and valid are held.
- R10: While reset is asserted, `out_valid_o`, `in_ready_o`, `cmd_ready_o` and `len_err_o` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_mac_i | input | 48 | Local source address, captured once after reset |
| dst_we_i | input | 1 | Destination address write strobe |
| dst_mac_i | input | 48 | Destination address write value |
| slot_id_i | input | 8 | Board slot identifier |
| cmd_valid_i | input | 1 | Frame command valid |
| cmd_len_i | input | 12 | Payload byte count of the command |
| cmd_slot_i | input | 1 | Insert slot identifier as first data byte |
| cmd_ready_o | output | 1 | Command can be accepted |
| in_valid_i | input | 1 | Payload byte valid |
| in_data_i | input | 8 | Payload byte |
| in_ready_o | output | 1 | Payload byte accepted |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_sof_o | output | 1 | First byte of a frame |
| out_eof_o | output | 1 | Last byte of a frame |
| out_ready_i | input | 1 | Sink accepts output byte |
| len_err_o | output | 1 | Sticky oversize flag |

## Verification
The in-module assertions check several properties on every cycle:

- the payload input is closed during the header;
- header, slot and pad bytes are held under backpressure;
- the error flag never falls;
- the captured source address never moves;
- the destination register is frozen during a frame;
- the length field stays within 46 to 1500.

Only the bench's scenarios can show that the bytes are correct, in the right order and at the right positions. This covers the length arithmetic at the padding and truncation boundaries, slot insertion, draining of surplus bytes, and which destination value a write made mid-frame or in idle leaves behind.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HDR   = 3'd1,
    ST_SLOT  = 3'd2,
    ST_DATA  = 3'd3,
    ST_PAD   = 3'd4,
    ST_DRAIN = 3'd5
  } tx_state_t;

  localparam int HDR_LEN = 14;
  localparam int MAC_W   = 48;
endpackage

// File: rtl/eth_tx_rst_sync.sv
module eth_tx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/eth_tx_sizer.sv
// Turns a command into sent, field and discard counts.
// LEN_W + 1 must be at least CNT_W.
module eth_tx_sizer #(
  parameter int MIN_DATA = 46,
  parameter int MAX_DATA = 1500,
  parameter int LEN_W    = 12,
  parameter int CNT_W    = 11
) (
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_slot,
  output logic [CNT_W-1:0] n_send,
  output logic [CNT_W-1:0] n_field,
  output logic [LEN_W:0]   n_drop,
  output logic             over
);
  localparam logic [LEN_W:0]   MAX_V = (LEN_W+1)'(MAX_DATA);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_DATA);

  logic [LEN_W:0] n_total;
  logic [LEN_W:0] capped;

  assign n_total = {1'b0, req_len} + {{LEN_W{1'b0}}, req_slot};
  assign over    = (n_total > MAX_V);
  assign capped  = over ? MAX_V : n_total;
  assign n_send  = capped[CNT_W-1:0];
  assign n_field = (n_send < MIN_V) ? MIN_V : n_send;
  assign n_drop  = n_total - capped;
endmodule

// File: rtl/eth_tx_hdr_sel.sv
// Picks header byte idx out of {dst, src, length}, most significant first.
module eth_tx_hdr_sel #(
  parameter int CNT_W = 11
) (
  input  logic [3:0]       idx,
  input  logic [47:0]      dst,
  input  logic [47:0]      src,
  input  logic [CNT_W-1:0] field,
  output logic [7:0]       hbyte
);
  localparam int HB = eth_tx_pkg::HDR_LEN;

  logic [8*HB-1:0] hdr;

  assign hdr = {dst, src, 16'(field)};

  always_comb begin
    hbyte = 8'h00;
    for (int b = 0; b < HB; b++) begin
      if (idx == 4'(b)) hbyte = hdr[8*HB-1-8*b -: 8];
    end
  end
endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
  import eth_tx_pkg::*;
#(
  parameter int MIN_DATA = 46,
  parameter int MAX_DATA = 1500,
  parameter int LEN_W    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [47:0]      src_mac_i,
  input  logic             dst_we_i,
  input  logic [47:0]      dst_mac_i,
  input  logic [7:0]       slot_id_i,
  input  logic             cmd_valid_i,
  input  logic [LEN_W-1:0] cmd_len_i,
  input  logic             cmd_slot_i,
  output logic             cmd_ready_o,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic [7:0]       out_data_o,
  output logic             out_sof_o,
  output logic             out_eof_o,
  input  logic             out_ready_i,
  output logic             len_err_o
);
  localparam int CNT_W = $clog2(MAX_DATA + 1);

  logic rst_n_s;

  tx_state_t        state_q, state_d;
  logic [3:0]       idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_nx;
  logic [CNT_W-1:0] send_q, send_d, field_q, field_d;
  logic [LEN_W:0]   drop_q, drop_d;
  logic [7:0]       slotv_q, slotv_d;
  logic             slot_q, slot_d, err_q, err_d;
  logic [47:0]      src_q, dst_q;
  logic             src_ok_q;

  logic [CNT_W-1:0] sz_send, sz_field;
  logic [LEN_W:0]   sz_drop;
  logic             sz_over;
  logic [7:0]       hdr_byte;
  logic             cmd_fire, out_fire, in_fire, in_body, at_end;

  eth_tx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  eth_tx_sizer #(
    .MIN_DATA (MIN_DATA),
    .MAX_DATA (MAX_DATA),
    .LEN_W    (LEN_W),
    .CNT_W    (CNT_W)
  ) u_size (
    .req_len  (cmd_len_i),
    .req_slot (cmd_slot_i),
    .n_send   (sz_send),
    .n_field  (sz_field),
    .n_drop   (sz_drop),
    .over     (sz_over)
  );

  eth_tx_hdr_sel #(.CNT_W(CNT_W)) u_hdr (
    .idx   (idx_q),
    .dst   (dst_q),
    .src   (src_q),
    .field (field_q),
    .hbyte (hdr_byte)
  );

  // Handshakes and outputs
  assign cmd_ready_o = (state_q == ST_IDLE) && src_ok_q;
  assign in_ready_o  = ((state_q == ST_DATA) && out_ready_i) || (state_q == ST_DRAIN);
  assign out_valid_o = (state_q == ST_HDR) || (state_q == ST_SLOT) ||
                       (state_q == ST_PAD) || ((state_q == ST_DATA) && in_valid_i);
  assign in_body     = (state_q == ST_SLOT) || (state_q == ST_DATA) || (state_q == ST_PAD);
  assign at_end      = (cnt_q == field_q - 1'b1);
  assign out_sof_o   = (state_q == ST_HDR) && (idx_q == 4'd0);
  assign out_eof_o   = in_body && at_end;
  assign len_err_o   = err_q;

  assign cmd_fire = cmd_valid_i && cmd_ready_o;
  assign out_fire = out_valid_o && out_ready_i;
  assign in_fire  = in_valid_i && in_ready_o;
  assign cnt_nx   = cnt_q + 1'b1;

  always_comb begin
    unique case (state_q)
      ST_HDR:  out_data_o = hdr_byte;
      ST_SLOT: out_data_o = slotv_q;
      ST_DATA: out_data_o = in_data_i;
      default: out_data_o = 8'h00;
    endcase
  end

  // Next state
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    send_d  = send_q;
    field_d = field_q;
    drop_d  = drop_q;
    slot_d  = slot_q;
    slotv_d = slotv_q;
    err_d   = err_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_fire) begin
          state_d = ST_HDR;
          idx_d   = 4'd0;
          cnt_d   = '0;
          send_d  = sz_send;
          field_d = sz_field;
          drop_d  = sz_drop;
          slot_d  = cmd_slot_i;
          slotv_d = slot_id_i;
          if (sz_over) err_d = 1'b1;
        end
      end
      ST_HDR: begin
        if (out_fire) begin
          if (idx_q == 4'(HDR_LEN - 1)) begin
            if (slot_q)            state_d = ST_SLOT;
            else if (send_q != '0) state_d = ST_DATA;
            else                   state_d = ST_PAD;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_SLOT, ST_DATA, ST_PAD: begin
        if (out_fire) begin
          cnt_d = cnt_nx;
          if (at_end)               state_d = (drop_q != '0) ? ST_DRAIN : ST_IDLE;
          else if (cnt_nx < send_q) state_d = ST_DATA;
          else                      state_d = ST_PAD;
        end
      end
      ST_DRAIN: begin
        if (in_fire) begin
          drop_d = drop_q - 1'b1;
          if (drop_q == {{LEN_W{1'b0}}, 1'b1}) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      idx_q   <= 4'd0;
      cnt_q   <= '0;
      send_q  <= '0;
      field_q <= CNT_W'(MIN_DATA);
      drop_q  <= '0;
      slot_q  <= 1'b0;
      slotv_q <= 8'h00;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      send_q  <= send_d;
      field_q <= field_d;
      drop_q  <= drop_d;
      slot_q  <= slot_d;
      slotv_q <= slotv_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      src_q    <= '0;
      src_ok_q <= 1'b0;
    end else if (!src_ok_q) begin
      src_q    <= src_mac_i;
      src_ok_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      dst_q <= '0;
    end else if (dst_we_i && (state_q == ST_IDLE)) begin
      dst_q <= dst_mac_i;
    end
  end

  // Assertions
  a_r4_no_input_in_hdr: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_HDR) |-> !in_ready_o);

  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n_s)
    (out_valid_o && !out_ready_i && state_q != ST_DATA) |=> (out_valid_o && $stable(out_data_o)));

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n_s)
    err_q |=> err_q);

  a_r7_src_fixed: assert property (@(posedge clk) disable iff (!rst_n_s)
    src_ok_q |=> $stable(src_q));

  a_r8_dst_frozen: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q != ST_IDLE) |=> $stable(dst_q));

  a_r2_field_range: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q != ST_IDLE) |-> (field_q >= CNT_W'(MIN_DATA) && field_q <= CNT_W'(MAX_DATA)));

  a_r9_eof_ends: assert property (@(posedge clk) disable iff (!rst_n_s)
    (out_eof_o && out_ready_i) |=> (state_q == ST_IDLE || state_q == ST_DRAIN));
endmodule

// File: tb/tb_eth_tx_framer.sv
module tb_eth_tx_framer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [47:0] src_mac, dst_mac;
  logic        dst_we;
  logic [7:0]  slot_id;
  logic        cmd_valid, cmd_slot, cmd_ready;
  logic [11:0] cmd_len;
  logic        in_valid, in_ready;
  logic [7:0]  in_data;
  logic        out_valid, out_sof, out_eof, out_ready;
  logic [7:0]  out_data;
  logic        len_err;

  always #5 clk = ~clk;

  eth_tx_framer dut (
    .clk(clk), .rst_n(rst_n), .src_mac_i(src_mac), .dst_we_i(dst_we),
    .dst_mac_i(dst_mac), .slot_id_i(slot_id), .cmd_valid_i(cmd_valid),
    .cmd_len_i(cmd_len), .cmd_slot_i(cmd_slot), .cmd_ready_o(cmd_ready),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_sof_o(out_sof),
    .out_eof_o(out_eof), .out_ready_i(out_ready), .len_err_o(len_err)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [47:0] exp_dst, exp_src;
  logic [7:0]  got_b [0:2047];
  int          got_n;
  int          mark_bad, hold_bad, hdr_in_bad;

  // {len[11:0], slot mode, backpressure}
  localparam logic [13:0] VEC [0:7] = '{
    {12'd46,   1'b0, 1'b0},
    {12'd10,   1'b0, 1'b1},
    {12'd0,    1'b1, 1'b0},
    {12'd100,  1'b1, 1'b1},
    {12'd1500, 1'b0, 1'b0},
    {12'd45,   1'b1, 1'b1},
    {12'd0,    1'b0, 1'b0},
    {12'd1499, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int k, input logic [7:0] seed);
    return 8'(k * 7 + 3) ^ seed;
  endfunction

  task automatic run_frame(input int len, input bit stat, input bit bp,
                           input bit mid_dst, input logic [7:0] seed, input bit exp_err);
    int n, send, f, c;
    bit done, stall;
    logic [7:0] held, e;
    bit hb, fb, db, pb;
    logic [7:0] ha, he, fa, fe, da, de, pa, pe;
    n    = len + (stat ? 1 : 0);
    send = (n > 1500) ? 1500 : n;
    f    = (send < 46) ? 46 : send;
    got_n = 0; mark_bad = 0; hold_bad = 0; hdr_in_bad = 0;
    fork
      begin
        @(negedge clk);
        cmd_valid = 1'b1; cmd_len = 12'(len); cmd_slot = stat;
        #4;
        while (!cmd_ready) begin @(negedge clk); #4; end
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int k = 0; k < len; k++) begin
          in_valid = 1'b1; in_data = pat(k, seed);
          #4;
          while (!in_ready) begin @(negedge clk); #4; end
          @(negedge clk);
        end
        in_valid = 1'b0;
      end
      begin
        done = 0; c = 0; stall = 0; held = 8'h00;
        while (!done && got_n < 2048) begin
          @(negedge clk);
          out_ready = bp ? ((c % 3) != 2) : 1'b1;
          c++;
          #4;
          if (stall && (!out_valid || out_data != held)) hold_bad++;
          stall = out_valid && !out_ready;
          held  = out_data;
          if (got_n < 14 && in_ready) hdr_in_bad++;
          if (out_valid && out_ready) begin
            got_b[got_n] = out_data;
            if (out_sof != (got_n == 0)) mark_bad++;
            if (out_eof != (got_n == 14 + f - 1)) mark_bad++;
            if (out_eof) done = 1;
            got_n++;
          end
        end
        out_ready = 1'b1;
      end
      begin
        if (mid_dst) begin
          repeat (30) @(negedge clk);
          dst_we = 1'b1; dst_mac = 48'hDEAD_0000_BEEF;
          @(negedge clk);
          dst_we = 1'b0;
        end
      end
    join
    hb = 0; fb = 0; db = 0; pb = 0;
    ha = 0; he = 0; fa = 0; fe = 0; da = 0; de = 0; pa = 0; pe = 0;
    for (int i = 0; i < got_n && i < 14 + f; i++) begin
      if (i < 6)       e = exp_dst[47-8*i -: 8];
      else if (i < 12) e = exp_src[47-8*(i-6) -: 8];
      else if (i == 12) e = 8'(f >> 8);
      else if (i == 13) e = 8'(f);
      else if (i - 14 < send) e = (stat && i == 14) ? slot_id : pat(i - 14 - (stat ? 1 : 0), seed);
      else e = 8'h00;
      if (got_b[i] != e) begin
        if (i < 12 && !hb)            begin hb = 1; ha = got_b[i]; he = e; end
        else if (i >= 12 && i < 14 && !fb) begin fb = 1; fa = got_b[i]; fe = e; end
        else if (i >= 14 && i - 14 < send && !db) begin db = 1; da = got_b[i]; de = e; end
        else if (i - 14 >= send && !pb) begin pb = 1; pa = got_b[i]; pe = e; end
      end
    end
    chk(!hb, "R1 address header", ha, he);
    chk(!fb, "R2 length field", fa, fe);
    chk(got_n == 14 + f, "R2 frame byte count", got_n, 14 + f);
    chk(!db, stat ? "R5 slot byte and R4 payload" : "R4 payload bytes", da, de);
    chk(!pb, "R3 zero padding", pa, pe);
    chk(hdr_in_bad == 0, "R4 input closed during header", hdr_in_bad, 0);
    chk(mark_bad == 0, "R9 sof/eof markers", mark_bad, 0);
    if (bp) chk(hold_bad == 0, "R9 hold under backpressure", hold_bad, 0);
    chk(len_err == exp_err, "R6 error flag", len_err, exp_err);
    @(negedge clk); @(negedge clk);
    chk(cmd_ready == 1'b1, "R6 ready for next command", cmd_ready, 1);
  endtask

  task automatic do_reset(input logic [47:0] src_val);
    rst_n = 1'b0;
    src_mac = src_val;
    repeat (3) @(negedge clk);
    chk(!out_valid && !in_ready && !cmd_ready && !len_err, "R10 outputs low in reset",
        {out_valid, in_ready, cmd_ready, len_err}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    exp_src = src_val;
    src_mac = ~src_val;   // R7: later input changes must not matter
  endtask

  task automatic write_dst(input logic [47:0] v);
    @(negedge clk);
    dst_we = 1'b1; dst_mac = v;
    @(negedge clk);
    dst_we = 1'b0;
    exp_dst = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    dst_we = 0; dst_mac = '0; slot_id = 8'h5A;
    cmd_valid = 0; cmd_len = '0; cmd_slot = 0;
    in_valid = 0; in_data = '0; out_ready = 1;
    do_reset(48'h0200_1122_3344);
    write_dst(48'hFFEE_DDCC_BBAA);

    // R1 R2 R3 R4 R5 R9: table of frames
    for (int v = 0; v < 8; v++) begin
      run_frame(int'(VEC[v][13:2]), VEC[v][1], VEC[v][0], 1'b0, 8'(v * 17), 1'b0);
    end

    // R8: write during a frame is ignored now and later
    run_frame(100, 1'b0, 1'b0, 1'b1, 8'h11, 1'b0);
    run_frame(20, 1'b0, 1'b0, 1'b0, 8'h22, 1'b0);
    // R8: write while idle takes effect
    write_dst(48'h0A0B_0C0D_0E0F);
    run_frame(50, 1'b1, 1'b0, 1'b0, 8'h33, 1'b0);

    // R6: oversize truncated, surplus drained, flag sticky
    run_frame(1503, 1'b0, 1'b1, 1'b0, 8'h44, 1'b1);
    run_frame(1500, 1'b1, 1'b0, 1'b0, 8'h55, 1'b1);
    run_frame(20, 1'b0, 1'b0, 1'b0, 8'h66, 1'b1);

    // R7 R10: new reset clears flag and recaptures the source address
    do_reset(48'h0600_7788_99AB);
    chk(len_err == 1'b0, "R6 flag cleared by reset", len_err, 0);
    exp_dst = 48'h0;
    run_frame(60, 1'b0, 1'b1, 1'b0, 8'h77, 1'b0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule